// File: doc/BRIEF.md
# Soft Reset and Clock Gate Control Register

This block is a small per-module control register that owns two bits: a soft-reset request at bit 31 and a clock-gate flag at bit 30. It drives a reset line and a clock-enable line into the module it guards. Software changes the bits through four write offsets. One offset loads the whole register. The other three offsets change only the bits written as one: one sets them, one clears them and one inverts them, so no read-modify-write is needed.

A soft-reset request passes through a settling pipeline before it shows up on the reset output and in the read value. Once the settled reset has stayed high for a programmable number of cycles, the hardware sets the clock-gate bit by itself. Software polls for that bit to learn that the reset has completed.

A full reset is done in this order: release reset, ungate, assert reset, poll until the gate reads set, release reset, ungate. To only enable the module, software releases reset and ungates it without ever requesting reset. The read value always shows the live state.

Top module: `srst_cgate_ctrl`

## Requirements
- R1: While rst_n is low and just after it is released, rd_data reads 0xC000_0000, mod_rst is 1 and mod_clk_en is 0.
- R2: A write at offset 0x0 (wr_addr[3:2]=0) loads the reset request from wr_data[31] and the gate bit from wr_data[30].
- R3: A write at offset 0x4 (wr_addr[3:2]=1) sets each of bit 31 and bit 30 whose wr_data bit is one and leaves the other unchanged.
- R4: A write at offset 0x8 (wr_addr[3:2]=2) clears each of bit 31 and bit 30 whose wr_data bit is one and leaves the other unchanged.
- R5: A write at offset 0xC (wr_addr[3:2]=3) inverts each of bit 31 and bit 30 whose wr_data bit is one.
- R6: A change of the reset request appears on rd_data[31] and mod_rst exactly SETTLE_CYCLES clock edges after the write edge (3 by default). A write to the gate bit appears on rd_data[30] after the write edge itself.
- R7: After the settled reset has been high for GATE_DELAY edges (4 by default), the hardware sets bit 30, at the edge SETTLE_CYCLES+GATE_DELAY after the reset-request write. If software clears bit 30 at that same edge, the hardware set wins.
- R8: The hardware never sets bit 30 while the settled reset is low, so the enable-only path leaves the gate clear.
- R9: mod_rst equals the settled reset (rd_data[31]), and mod_clk_en is the inverse of bit 30.
- R10: rd_data[29:0] always read zero, writes to wr_data[29:0] have no effect, and wr_addr[1:0] plays no part in the decode.
- R11: The hardware sets the gate only once for each assertion of the settled reset. If software clears bit 30 while the reset is still settled high, bit 30 stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the register and of the guarded module |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| wr_en | input | 1 | Write strobe; every cycle in which it is high is one accepted write |
| wr_addr | input | 4 | Byte offset of the write; bits 3:2 select load, set, clear or invert |
| wr_data | input | 32 | Write data; only bits 31 and 30 are used |
| rd_data | output | 32 | Live register value: settled reset at bit 31, gate at bit 30 |
| mod_rst | output | 1 | Reset to the guarded module, high while the settled reset is set |
| mod_clk_en | output | 1 | Clock enable to the guarded module, low while the gate bit is set |

## Verification
A stage of the settling pipeline that holds the wrong value shows up on rd_data[31] and mod_rst within SETTLE_CYCLES edges. Because the bench compares against its model on every clock, the failure is reported on that edge. A wrong count or a stale completion flag moves the hardware gate-set edge, or makes the gate set again after software cleared it. Either case is seen on rd_data[30] and mod_clk_en at the very edge where the model differs. A decode fault is visible one edge after the write, on the gate bit.

// File: rtl/scg_pkg.sv
`timescale 1ns/1ps
package scg_pkg;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 4;
  localparam int OP_LSB    = 2;
  localparam int SRST_POS  = 31;
  localparam int CGATE_POS = 30;

  // Write offset selects how the written ones act on the controlled bits.
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TGL  = 2'd3
  } alias_op_e;
endpackage

// File: rtl/scg_bit_update.sv
`timescale 1ns/1ps
module scg_bit_update
  import scg_pkg::*;
(
  input  logic      wr_en,
  input  alias_op_e op,
  input  logic      cur,
  input  logic      wbit,
  output logic      nxt
);
  always_comb begin
    nxt = cur;
    if (wr_en) begin
      unique case (op)
        OP_LOAD: nxt = wbit;
        OP_SET:  nxt = cur | wbit;
        OP_CLR:  nxt = cur & ~wbit;
        OP_TGL:  nxt = cur ^ wbit;
      endcase
    end
  end
endmodule

// File: rtl/scg_settle_pipe.sv
`timescale 1ns/1ps
module scg_settle_pipe #(
  parameter int   DEPTH   = 3,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] stage;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[0] <= RST_VAL;
        else        stage[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= RST_VAL;
        else        stage[i] <= stage[i-1];
      end
    end
  end

  assign dout = stage[DEPTH-1];
endmodule

// File: rtl/scg_gate_seq.sv
`timescale 1ns/1ps
module scg_gate_seq #(
  parameter int GATE_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  output logic hw_set
);
  localparam int CNT_W = $clog2(GATE_DELAY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GATE_DELAY - 1);

  logic [CNT_W-1:0] cnt;
  logic             done;

  assign hw_set = live && !done && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b1;
    end else if (!live) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (hw_set) begin
      cnt  <= '0;
      done <= 1'b1;
    end else if (!done) begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/srst_cgate_ctrl.sv
`timescale 1ns/1ps
module srst_cgate_ctrl
  import scg_pkg::*;
#(
  parameter int SETTLE_CYCLES = 3,
  parameter int GATE_DELAY    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              mod_rst,
  output logic              mod_clk_en
);
  alias_op_e op;
  logic      srst_req, srst_req_nxt;
  logic      cgate, cgate_nxt;
  logic      srst_live;
  logic      gate_hw_set;
  logic      unused_bits;

  assign op          = alias_op_e'(wr_addr[OP_LSB+1:OP_LSB]);
  assign unused_bits = ^{wr_addr[OP_LSB-1:0], wr_data[CGATE_POS-1:0]};

  scg_bit_update u_req_upd (
    .wr_en (wr_en),
    .op    (op),
    .cur   (srst_req),
    .wbit  (wr_data[SRST_POS]),
    .nxt   (srst_req_nxt)
  );

  scg_bit_update u_gate_upd (
    .wr_en (wr_en),
    .op    (op),
    .cur   (cgate),
    .wbit  (wr_data[CGATE_POS]),
    .nxt   (cgate_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_req <= 1'b1;
      cgate    <= 1'b1;
    end else begin
      srst_req <= srst_req_nxt;
      cgate    <= cgate_nxt | gate_hw_set;
    end
  end

  scg_settle_pipe #(
    .DEPTH   (SETTLE_CYCLES),
    .RST_VAL (1'b1)
  ) u_pipe (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (srst_req),
    .dout (srst_live)
  );

  scg_gate_seq #(
    .GATE_DELAY (GATE_DELAY)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .live   (srst_live),
    .hw_set (gate_hw_set)
  );

  always_comb begin
    rd_data            = '0;
    rd_data[SRST_POS]  = srst_live;
    rd_data[CGATE_POS] = cgate;
  end

  assign mod_rst    = srst_live;
  assign mod_clk_en = ~cgate;
endmodule

// File: rtl/scg_checker.sv
`timescale 1ns/1ps
module scg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  op_bits,
  input logic [1:0]  wbits,
  input logic [31:0] rd_data,
  input logic        mod_rst,
  input logic        mod_clk_en,
  input logic        srst_req,
  input logic        gate_hw_set
);
  assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_bits == 2'd1 && wbits[1]) |=> srst_req);

  assert_clr_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_bits == 2'd2 && wbits[0]) |=> (!rd_data[30] || $past(gate_hw_set)));

  assert_hw_gate_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[30]) |-> ($past(wr_en) || $past(mod_rst)));

  assert_clk_en_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_clk_en) |-> $past(wr_en));

  assert_low_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[29:0] == 30'd0);

  assert_hw_set_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hw_set |=> !gate_hw_set);
endmodule

bind srst_cgate_ctrl scg_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .op_bits    (wr_addr[3:2]),
  .wbits      (wr_data[31:30]),
  .rd_data    (rd_data),
  .mod_rst    (mod_rst),
  .mod_clk_en (mod_clk_en),
  .srst_req   (srst_req),
  .gate_hw_set(gate_hw_set)
);

// File: tb/sim_srst_cgate_ctrl.sv
`timescale 1ns/1ps
module sim_srst_cgate_ctrl;
  localparam int SETTLE = 3;
  localparam int GATE   = 4;
  localparam logic [31:0] SR = 32'h8000_0000;
  localparam logic [31:0] CG = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        mod_rst, mod_clk_en;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  srst_cgate_ctrl #(.SETTLE_CYCLES(SETTLE), .GATE_DELAY(GATE)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data(rd_data), .mod_rst(mod_rst),
    .mod_clk_en(mod_clk_en)
  );

  always #2 clk = ~clk;

  // Behavioural reference: request bit, a queue of in-flight requests,
  // gate bit and a completion counter.
  bit m_req, m_cgate, m_done;
  bit m_q[$];
  int m_cnt;

  function automatic bit apply_op(bit cur, bit d, logic [1:0] sel);
    case (sel)
      2'd0:    return d;
      2'd1:    return cur | d;
      2'd2:    return cur & ~d;
      default: return cur ^ d;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit live_pre, hw, req_n, cg_n;
    if (!rst_n) begin
      m_req = 1; m_cgate = 1; m_done = 1; m_cnt = 0;
      m_q.delete();
      for (int i = 0; i < SETTLE; i++) m_q.push_back(1'b1);
    end else begin
      live_pre = m_q[0];
      hw    = 0;
      req_n = m_req;
      cg_n  = m_cgate;
      if (wr_en) begin
        req_n = apply_op(m_req, wr_data[31], wr_addr[3:2]);
        cg_n  = apply_op(m_cgate, wr_data[30], wr_addr[3:2]);
      end
      if (!live_pre) begin
        m_cnt = 0; m_done = 0;
      end else if (!m_done) begin
        if (m_cnt == GATE - 1) begin hw = 1; m_done = 1; m_cnt = 0; end
        else m_cnt++;
      end
      void'(m_q.pop_front());
      m_q.push_back(m_req);
      m_req   = req_n;
      m_cgate = cg_n | hw;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      #1;
      chk("R6 model", {31'd0, rd_data[31]}, {31'd0, m_q[0]});
      chk("R7 model", {31'd0, rd_data[30]}, {31'd0, m_cgate});
      chk("R10 model", {2'd0, rd_data[29:0]}, 32'd0);
      chk("R9 model rst", {31'd0, mod_rst}, {31'd0, m_q[0]});
      chk("R9 model clken", {31'd0, mod_clk_en}, {31'd0, ~m_cgate});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset state
    idle(3);
    chk("R1 rd", rd_data, 32'hC000_0000);
    chk("R1 rst", {31'd0, mod_rst}, 32'd1);
    chk("R1 clken", {31'd0, mod_clk_en}, 32'd0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 after release", rd_data, 32'hC000_0000);

    // R8 enable-only path, R6 settle timing
    wr(4'h8, SR);
    idle(2);
    chk("R6 not yet", {31'd0, rd_data[31]}, 32'd1);
    idle(1);
    chk("R6 settled", {31'd0, rd_data[31]}, 32'd0);
    chk("R9 rst low", {31'd0, mod_rst}, 32'd0);
    wr(4'h8, CG);
    chk("R4 gate clear", rd_data, 32'd0);
    chk("R9 clken", {31'd0, mod_clk_en}, 32'd1);
    idle(20);
    chk("R8 no hw gate", rd_data, 32'd0);

    // R7 full reset with hardware completion
    wr(4'h4, SR);
    idle(2);
    chk("R6 set pending", {31'd0, rd_data[31]}, 32'd0);
    idle(1);
    chk("R6 set settled", {31'd0, rd_data[31]}, 32'd1);
    chk("R9 rst high", {31'd0, mod_rst}, 32'd1);
    idle(3);
    chk("R7 gate not yet", {31'd0, rd_data[30]}, 32'd0);
    idle(1);
    chk("R7 gate set", {31'd0, rd_data[30]}, 32'd1);
    chk("R9 clken off", {31'd0, mod_clk_en}, 32'd0);

    // R11 software clear during live reset stays clear
    wr(4'h8, CG);
    chk("R11 cleared", rd_data, SR);
    idle(10);
    chk("R11 stays clear", rd_data, SR);
    wr(4'h8, SR);
    idle(3);
    chk("R6 release", rd_data, 32'd0);

    // R2 load offset
    wr(4'h0, CG);
    chk("R2 load gate", rd_data, CG);
    wr(4'h0, 32'd0);
    chk("R2 load zero", rd_data, 32'd0);

    // R5 invert offset
    wr(4'hC, CG);
    chk("R5 toggle on", rd_data, CG);
    wr(4'hC, CG);
    chk("R5 toggle off", rd_data, 32'd0);
    wr(4'hC, SR);
    idle(3);
    chk("R5 toggle srst", rd_data, SR);
    idle(4);
    chk("R7 gate via toggle", rd_data, 32'hC000_0000);
    wr(4'hC, SR);
    idle(3);
    chk("R5 toggle srst off", rd_data, CG);

    // R10 low bits and address LSBs ignored
    wr(4'h1, 32'h3FFF_FFFF);
    chk("R10 load low bits", rd_data, 32'd0);
    wr(4'h6, 32'h7FFF_FFFF);
    idle(3);
    chk("R10 set with lsbs", rd_data, CG);

    // R3 / R4 zeros leave bits unchanged
    wr(4'h4, 32'd0);
    chk("R3 zero set", rd_data, CG);
    wr(4'h8, 32'd0);
    chk("R4 zero clear", rd_data, CG);

    // R7 hardware set wins over same-edge software clear
    wr(4'h8, CG);
    chk("R4 clear gate", rd_data, 32'd0);
    wr(4'h4, SR);
    idle(5);
    wr(4'h8, CG);
    chk("R7 hw wins", rd_data, 32'hC000_0000);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run", rd_data, 32'hC000_0000);
    chk("R1 mid-run clken", {31'd0, mod_clk_en}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    chk("R1 after second release", rd_data, 32'hC000_0000);

    finish_run();
  end
endmodule